// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer

This block is the digital half of an 8-bit successive-approximation analog-to-digital converter. It divides the system clock down to a slower converter tick and runs a fixed schedule on that tick: a sample window, while the sample switch is closed on the selected analog channel, and then one trial per result bit. During each trial it drives a code to an external DAC, reads a single comparator bit, and builds up the result from the most significant bit down.

Software programs the block through a control word that holds a run bit and a 4-bit channel number. The block reports the run bit, the channel, a sticky completion flag and the last finished result. After a write that sets the run bit, the block converts the selected channel over and over without pausing. Each new result replaces the previous one only at the moment that conversion completes. Another enabling write abandons the conversion in progress and starts over. A write that clears the run bit halts the sequencer at once. The sample capacitor, the DAC, the comparator and the input multiplexer are outside this block.

Top module: `sar_adc_seq`

## Requirements
- R1: After a synchronous reset, the run bit, the completion flag, the result, the sample-switch enable, the DAC code and the channel-select output are all zero.
- R2: The converter tick occurs once every 4 system clocks. A conversion spans 12 ticks, so the completion flag reads 1 exactly 48 clocks after the clock edge that captured an enabling write.
- R3: A conversion begins with a sample window of 4 ticks (16 clocks), during which the sample-switch enable is 1 and the DAC code is 0. It is followed by 8 trial ticks, during which the sample-switch enable is 0.
- R4: Trials go from MSB to LSB. On entering the trial window the DAC code is 80h. At each trial tick, the bit under test is kept when the comparator input is 1 (input at or above the trial level) and cleared when it is 0, and the next lower bit is set.
- R5: The result equals the input level: an input at or above full scale gives FFh, an input of zero gives 00h, and no overflow indication exists.
- R6: While the run bit is set, a new sample window begins on the same edge that completes a conversion, so results arrive every 48 clocks. Completion raises the flag, and no interrupt output exists.
- R7: A control write with the run bit set clears the completion flag, abandons the conversion in progress and starts a new sample window on the same edge.
- R8: The result output changes only on the edge that completes a conversion, and it holds its value through the whole of the following conversion.
- R9: The channel-select output takes the written channel when a conversion is started by a write, and it is re-latched only at the start of each sample window. It stays stable in between.
- R10: A control write with the run bit clear stops the sequencer on that edge. Sample enable and DAC code go to 0, no further conversion completes, and the result and completion flag keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr | input | 1 | Control-word write strobe, one clock |
| wr_run | input | 1 | Run bit of the written control word |
| wr_chan | input | 4 | Channel field of the written control word |
| cmp_in | input | 1 | Comparator result: 1 when the input is at or above the DAC level |
| stat_run | output | 1 | Run bit readback |
| stat_chan | output | 4 | Channel field readback |
| stat_done | output | 1 | Sticky completion flag |
| data_out | output | 8 | Last completed conversion result |
| chan_sel | output | 4 | Analog multiplexer select |
| sample_en | output | 1 | Sample-switch close enable |
| dac_code | output | 8 | Trial code for the external DAC |

## Verification
On every cycle the assertions check the following. Tick spacing. A zero DAC code while the switch is closed. The 80h code when the trial window opens. The flag and phase effects of both kinds of write. A result and channel select that change only at their permitted edges. Only the bench's scenarios can show the exact 48-clock conversion period, the bit-by-bit trial codes, and the numeric results against a modelled comparator, including the values clamped at full scale. Those scenarios also cover the back-to-back results of continuous running and the lack of any completion after a stop.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOAD = 2'd1,
    PH_CONV = 2'd2
  } sar_phase_e;
endpackage

// File: rtl/sar_prescaler.sv
module sar_prescaler #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = run && !restart && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || restart || !run || tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sar_phase_fsm.sv
module sar_phase_fsm
  import sar_pkg::*;
#(
  parameter int LOAD_TICKS = 4,
  parameter int RES        = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic                   stop,
  input  logic                   tick,
  output logic                   in_load,
  output logic                   enter_conv,
  output logic                   step,
  output logic                   finish,
  output logic [$clog2(RES)-1:0] bit_idx
);
  localparam int MAXT = (LOAD_TICKS > RES) ? LOAD_TICKS : RES;
  localparam int TW   = $clog2(MAXT);
  localparam logic [TW-1:0] LOAD_LAST = TW'(LOAD_TICKS - 1);
  localparam logic [TW-1:0] CONV_LAST = TW'(RES - 1);
  localparam int IW = $clog2(RES);

  sar_phase_e    phase;
  logic [TW-1:0] tcnt;

  assign in_load    = (phase == PH_LOAD);
  assign enter_conv = tick && (phase == PH_LOAD) && (tcnt == LOAD_LAST);
  assign step       = tick && (phase == PH_CONV);
  assign finish     = step && (tcnt == CONV_LAST);
  // trial position counts down from the MSB
  assign bit_idx    = IW'(RES - 1) - IW'(tcnt);

  always_ff @(posedge clk) begin
    if (rst || stop) begin
      phase <= PH_IDLE;
      tcnt  <= '0;
    end else if (start) begin
      phase <= PH_LOAD;
      tcnt  <= '0;
    end else if (tick) begin
      unique case (phase)
        PH_LOAD: begin
          if (tcnt == LOAD_LAST) begin
            phase <= PH_CONV;
            tcnt  <= '0;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        PH_CONV: begin
          if (tcnt == CONV_LAST) begin
            phase <= PH_LOAD;
            tcnt  <= '0;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        default: begin
          phase <= PH_IDLE;
          tcnt  <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/sar_approx.sv
module sar_approx #(
  parameter int RES = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   clear,
  input  logic                   enter_conv,
  input  logic                   step,
  input  logic                   finish,
  input  logic [$clog2(RES)-1:0] bit_idx,
  input  logic                   cmp_in,
  output logic [RES-1:0]         trial,
  output logic [RES-1:0]         result
);
  localparam logic [RES-1:0] MSB_ONLY = {1'b1, {(RES-1){1'b0}}};

  logic [RES-1:0] decided;

  // resolve the bit under test and arm the next lower one
  always_comb begin
    decided = trial;
    decided[bit_idx] = cmp_in;
    if (bit_idx != '0) begin
      decided[bit_idx - 1'b1] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trial  <= '0;
      result <= '0;
    end else begin
      if (clear || finish) begin
        trial <= '0;
      end else if (enter_conv) begin
        trial <= MSB_ONLY;
      end else if (step) begin
        trial <= decided;
      end
      if (finish && !clear) begin
        result <= decided;
      end
    end
  end
endmodule

// File: rtl/sar_adc_seq.sv
module sar_adc_seq #(
  parameter int DIV        = 4,
  parameter int LOAD_TICKS = 4,
  parameter int RES        = 8,
  parameter int CHAN_W     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              wr_run,
  input  logic [CHAN_W-1:0] wr_chan,
  input  logic              cmp_in,
  output logic              stat_run,
  output logic [CHAN_W-1:0] stat_chan,
  output logic              stat_done,
  output logic [RES-1:0]    data_out,
  output logic [CHAN_W-1:0] chan_sel,
  output logic              sample_en,
  output logic [RES-1:0]    dac_code
);
  localparam int IW = $clog2(RES);

  logic          start;
  logic          stop;
  logic          tick;
  logic          in_load;
  logic          enter_conv;
  logic          step;
  logic          finish;
  logic [IW-1:0] bit_idx;
  logic          run_q;

  assign start = wr && wr_run;
  assign stop  = wr && !wr_run;

  sar_prescaler #(.DIV(DIV)) u_presc (
    .clk     (clk),
    .rst     (rst),
    .run     (run_q),
    .restart (start),
    .tick    (tick)
  );

  sar_phase_fsm #(.LOAD_TICKS(LOAD_TICKS), .RES(RES)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .stop       (stop),
    .tick       (tick),
    .in_load    (in_load),
    .enter_conv (enter_conv),
    .step       (step),
    .finish     (finish),
    .bit_idx    (bit_idx)
  );

  sar_approx #(.RES(RES)) u_sar (
    .clk        (clk),
    .rst        (rst),
    .clear      (wr),
    .enter_conv (enter_conv),
    .step       (step),
    .finish     (finish),
    .bit_idx    (bit_idx),
    .cmp_in     (cmp_in),
    .trial      (dac_code),
    .result     (data_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q     <= 1'b0;
      stat_chan <= '0;
      stat_done <= 1'b0;
      chan_sel  <= '0;
    end else begin
      if (wr) begin
        run_q     <= wr_run;
        stat_chan <= wr_chan;
      end
      if (start) begin
        stat_done <= 1'b0;
        chan_sel  <= wr_chan;
      end else if (finish && !stop) begin
        stat_done <= 1'b1;
        chan_sel  <= stat_chan;
      end
    end
  end

  assign stat_run  = run_q;
  assign sample_en = in_load;
endmodule

// File: rtl/sar_adc_seq_chk.sv
module sar_adc_seq_chk #(
  parameter int RES    = 8,
  parameter int CHAN_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              wr,
  input logic              wr_run,
  input logic              tick,
  input logic              finish,
  input logic              stat_run,
  input logic              stat_done,
  input logic [RES-1:0]    data_out,
  input logic [CHAN_W-1:0] chan_sel,
  input logic              sample_en,
  input logic [RES-1:0]    dac_code
);
  localparam logic [RES-1:0] MSB_ONLY = {1'b1, {(RES-1){1'b0}}};

  a_r2_tick_gap: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

  a_r3_load_code_zero: assert property (@(posedge clk) disable iff (rst)
    sample_en |-> (dac_code == '0));

  a_r4_msb_first: assert property (@(posedge clk) disable iff (rst)
    ($fell(sample_en) && stat_run) |-> (dac_code == MSB_ONLY));

  a_r6_done_on_finish: assert property (@(posedge clk) disable iff (rst)
    (finish && !wr) |=> (stat_done && sample_en));

  a_r7_restart: assert property (@(posedge clk) disable iff (rst)
    (wr && wr_run) |=> (!stat_done && sample_en && dac_code == '0));

  a_r8_result_hold: assert property (@(posedge clk) disable iff (rst)
    !finish |=> $stable(data_out));

  a_r9_chan_hold: assert property (@(posedge clk) disable iff (rst)
    (!wr && !finish) |=> $stable(chan_sel));

  a_r10_stop: assert property (@(posedge clk) disable iff (rst)
    (wr && !wr_run) |=> (!stat_run && !sample_en && dac_code == '0 && $stable(stat_done)));
endmodule

bind sar_adc_seq sar_adc_seq_chk #(.RES(RES), .CHAN_W(CHAN_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr        (wr),
  .wr_run    (wr_run),
  .tick      (tick),
  .finish    (finish),
  .stat_run  (stat_run),
  .stat_done (stat_done),
  .data_out  (data_out),
  .chan_sel  (chan_sel),
  .sample_en (sample_en),
  .dac_code  (dac_code)
);

// File: tb/sar_adc_seq_tb.sv
module sar_adc_seq_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr = 1'b0;
  logic       wr_run = 1'b0;
  logic [3:0] wr_chan = '0;
  logic       cmp_in;
  logic       stat_run, stat_done, sample_en;
  logic [3:0] stat_chan, chan_sel;
  logic [7:0] data_out, dac_code;

  logic [8:0] vin [16];
  int n_chk = 0;
  int n_bad = 0;
  bit ended = 0;

  always #4 clk = ~clk;

  // ideal comparator on the selected channel
  assign cmp_in = (vin[chan_sel] >= {1'b0, dac_code});

  sar_adc_seq u_dut (
    .clk(clk), .rst(rst), .wr(wr), .wr_run(wr_run), .wr_chan(wr_chan),
    .cmp_in(cmp_in), .stat_run(stat_run), .stat_chan(stat_chan),
    .stat_done(stat_done), .data_out(data_out), .chan_sel(chan_sel),
    .sample_en(sample_en), .dac_code(dac_code)
  );

  // {chan[20:17], level[16:8], expected[7:0]}
  localparam logic [20:0] VEC [7] = '{
    {4'd0,  9'd0,   8'h00},
    {4'd3,  9'd255, 8'hFF},
    {4'd5,  9'd300, 8'hFF},
    {4'd7,  9'd128, 8'h80},
    {4'd9,  9'd127, 8'h7F},
    {4'd1,  9'd1,   8'h01},
    {4'd15, 9'd165, 8'hA5}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  // returns at the negedge following the capturing edge
  task automatic csr_write(input bit run, input logic [3:0] ch);
    @(negedge clk);
    wr = 1'b1; wr_run = run; wr_chan = ch;
    @(posedge clk);
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic step_edges(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  // counts edges until completion, checking phase shape
  task automatic wait_done(output int k, output bit samp_ok);
    k = 0;
    samp_ok = 1;
    while (!stat_done && k < 200) begin
      if (sample_en != (k < 16)) samp_ok = 0;
      if (sample_en && dac_code != 8'h00) samp_ok = 0;
      step_edges(1);
      k++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int k;
    bit sok;
    logic [7:0] held;
    for (int c = 0; c < 16; c++) vin[c] = 9'd0;

    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check({stat_run, stat_done, sample_en} == 3'b000, "R1 flags", {stat_run, stat_done, sample_en}, 0);
    check(data_out == 8'h00 && dac_code == 8'h00, "R1 data/dac", {data_out, dac_code}, 0);
    check(chan_sel == 4'd0, "R1 chan_sel", chan_sel, 0);

    // table of levels walked by one loop: R2 R3 R5 R9
    for (int v = 0; v < 7; v++) begin
      vin[VEC[v][20:17]] = VEC[v][16:8];
      csr_write(1'b1, VEC[v][20:17]);
      check(chan_sel == VEC[v][20:17], "R9 channel latched", chan_sel, VEC[v][20:17]);
      wait_done(k, sok);
      check(k == 48, "R2 conversion length", k, 48);
      check(sok, "R3 sample window shape", 0, 1);
      check(data_out == VEC[v][7:0], "R5 result", data_out, VEC[v][7:0]);
    end

    // continuous running on ch15 (R6, R8)
    held = data_out;
    vin[15] = 9'h03C;
    step_edges(47);
    check(data_out == held, "R8 result held", data_out, held);
    check(stat_done, "R6 flag stays set", stat_done, 1);
    step_edges(1);
    check(data_out == 8'h3C, "R6 back-to-back result", data_out, 8'h3C);
    check(chan_sel == 4'd15, "R9 channel kept", chan_sel, 15);

    // abort mid-conversion (R7) and trial codes (R4)
    step_edges(20);
    vin[4] = 9'h05A;
    csr_write(1'b1, 4'd4);
    check(!stat_done, "R7 flag cleared", stat_done, 0);
    check(sample_en, "R7 restarted in sample", sample_en, 1);
    step_edges(16);
    check(dac_code == 8'h80, "R4 first trial", dac_code, 8'h80);
    step_edges(4);
    check(dac_code == 8'h40, "R4 msb dropped", dac_code, 8'h40);
    step_edges(4);
    check(dac_code == 8'h60, "R4 bit6 kept", dac_code, 8'h60);
    k = 24;
    while (!stat_done && k < 200) begin
      step_edges(1);
      k++;
    end
    check(k == 48, "R7 restart length", k, 48);
    check(data_out == 8'h5A, "R7 result", data_out, 8'h5A);

    // stop mid-conversion (R10)
    step_edges(25);
    vin[4] = 9'h001;
    csr_write(1'b0, 4'd4);
    check(!stat_run && !sample_en && dac_code == 8'h00, "R10 stopped",
          {stat_run, sample_en, dac_code}, 0);
    check(stat_done, "R10 flag kept", stat_done, 1);
    step_edges(120);
    check(data_out == 8'h5A, "R10 no new result", data_out, 8'h5A);
    check(!sample_en && dac_code == 8'h00, "R10 stays idle", {sample_en, dac_code}, 0);

    finish_run();
  end
endmodule